// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block watches eight general-purpose inputs, one per channel, and turns activity on them into eight interrupt request lines for a parent interrupt controller. Channel n drives request line n, which the parent sees as its interrupt number 32 + n. Each channel is configured on its own. In edge mode it detects rising edges, falling edges or both. In level mode it detects either a high level or a low level.

Software controls the block through a small register bus. The two enable registers each have a write-1-to-set alias and a write-1-to-clear alias, so one channel can be armed or disarmed without a read-modify-write. Edge events are latched in separate rising and falling flag registers. A status register reports what each channel is currently requesting and acknowledges edge interrupts. In level mode the falling-enable register takes a second role: it selects which input level is active.

The inputs are synchronised before use. An edge is found by comparing the current synchronised sample with the previous one.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the mode, both enable registers, both flag registers, the status register and every `irq_o` bit are 0.
- R2: Bit n of every register belongs to channel n. Word offsets are:
  - 0x00 mode (1 = level, 0 = edge)
  - 0x04 rising/level enable
  - 0x10 falling/polarity enable
  - 0x1C rising flags
  - 0x20 falling flags
  - 0x24 status

  Writes to 0x00, 0x04 and 0x10 replace the register. Reads of the set and clear aliases return the enable they act on. Unmapped offsets read 0, and bits above bit 7 read 0.
- R3: A write to 0x08 (or 0x14) sets every rising (or falling) enable bit whose data bit is 1 and leaves the others unchanged.
- R4: A write to 0x0C (or 0x18) clears every rising (or falling) enable bit whose data bit is 1 and leaves the others unchanged.
- R5: In edge mode, a rising edge on an input whose rising enable is 1 sets its rising flag. With the enable at 0 the flag is not set. A pin change reaches the flags by the third clock edge after it.
- R6: In edge mode, a falling edge on an input whose falling enable is 1 sets its falling flag. Both directions can be armed on one channel at once.
- R7: Writing 1 to a bit at 0x1C or 0x20 clears that flag. Bits written 0 leave their flags unchanged.
- R8: In edge mode, writing 1 to a status bit at 0x24 clears both flags of that channel.
- R9: If an armed edge is detected in the same cycle as a write that clears its flag, the flag ends set.
- R10: In level mode, status bit n = rising enable n AND (synchronised input n equals falling enable n). Writes to 0x24 do not change it, and the channel's flags stay 0.
- R11: `irq_o[n]` equals status bit n. In edge mode it stays asserted until a clear write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NCH | Watched inputs, one per channel, asynchronous |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| irq_o | output | NCH | Interrupt requests to the parent controller |

## Verification
The assertions check several rules on every cycle:
- the set and clear aliases change only the bits written as 1;
- an armed edge always leaves its flag set one cycle later, even against a clear;
- a level-mode channel never holds a flag;
- an edge-mode request never drops unless a clear write is present.

Only the bench's scenarios can show the rest: the exact register offsets and read values, the level polarity rule, the latency of the synchroniser, and the precise cycle of the edge-against-clear race. The bench checks these against an arithmetic model over swept pin patterns and enable masks.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned REG_AW = 6;
  typedef logic [REG_AW-1:0] reg_ofs_t;

  localparam reg_ofs_t OFS_MODE    = 6'h00;
  localparam reg_ofs_t OFS_REN     = 6'h04;
  localparam reg_ofs_t OFS_REN_SET = 6'h08;
  localparam reg_ofs_t OFS_REN_CLR = 6'h0C;
  localparam reg_ofs_t OFS_FEN     = 6'h10;
  localparam reg_ofs_t OFS_FEN_SET = 6'h14;
  localparam reg_ofs_t OFS_FEN_CLR = 6'h18;
  localparam reg_ofs_t OFS_RFLAG   = 6'h1C;
  localparam reg_ofs_t OFS_FFLAG   = 6'h20;
  localparam reg_ofs_t OFS_STAT    = 6'h24;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] smp_o,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);
  logic [NCH-1:0] stg_q [STAGES];
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign smp_o  = stg_q[STAGES-1];
  assign rise_o = smp_o & ~prev_q;
  assign fall_o = ~smp_o & prev_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  reg_ofs_t       addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] rflag_i,
  input  logic [NCH-1:0] fflag_i,
  input  logic [NCH-1:0] stat_i,
  output logic [NCH-1:0] mode_o,
  output logic [NCH-1:0] ren_o,
  output logic [NCH-1:0] fen_o,
  output logic [NCH-1:0] clr_r_o,
  output logic [NCH-1:0] clr_f_o,
  output logic [NCH-1:0] clr_st_o
);
  logic           wr;
  logic [NCH-1:0] wd;
  logic [NCH-1:0] mode_q, ren_q, fen_q, rsel;

  assign wr = req_i & we_i;
  assign wd = wdata_i[NCH-1:0];

  generate
    if (DW > NCH) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata_i[DW-1:NCH];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        OFS_MODE:    mode_q <= wd;
        OFS_REN:     ren_q  <= wd;
        OFS_REN_SET: ren_q  <= ren_q | wd;
        OFS_REN_CLR: ren_q  <= ren_q & ~wd;
        OFS_FEN:     fen_q  <= wd;
        OFS_FEN_SET: fen_q  <= fen_q | wd;
        OFS_FEN_CLR: fen_q  <= fen_q & ~wd;
        default: ;
      endcase
    end
  end

  assign clr_r_o  = (wr && addr_i == OFS_RFLAG) ? wd : '0;
  assign clr_f_o  = (wr && addr_i == OFS_FFLAG) ? wd : '0;
  assign clr_st_o = (wr && addr_i == OFS_STAT)  ? wd : '0;

  always_comb begin
    case (addr_i)
      OFS_MODE:                          rsel = mode_q;
      OFS_REN, OFS_REN_SET, OFS_REN_CLR: rsel = ren_q;
      OFS_FEN, OFS_FEN_SET, OFS_FEN_CLR: rsel = fen_q;
      OFS_RFLAG:                         rsel = rflag_i;
      OFS_FFLAG:                         rsel = fflag_i;
      OFS_STAT:                          rsel = stat_i;
      default:                           rsel = '0;
    endcase
  end

  assign rdata_o = DW'(rsel);
  assign mode_o  = mode_q;
  assign ren_o   = ren_q;
  assign fen_o   = fen_q;

  // R3: set alias only adds ones
  a_r3_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_REN_SET) |=> ren_q == ($past(ren_q) | $past(wd)));
  // R4: clear alias only removes ones
  a_r4_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_FEN_CLR) |=> fen_q == ($past(fen_q) & ~$past(wd)));
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic ren_i,
  input  logic fen_i,
  input  logic smp_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic clr_r_i,
  input  logic clr_f_i,
  input  logic clr_st_i,
  output logic rflag_o,
  output logic fflag_o,
  output logic stat_o
);
  logic rflag_q, fflag_q;

  // detection outranks a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rflag_q <= 1'b0;
      fflag_q <= 1'b0;
    end else if (lvl_i) begin
      rflag_q <= 1'b0;
      fflag_q <= 1'b0;
    end else begin
      if (rise_i && ren_i)          rflag_q <= 1'b1;
      else if (clr_r_i || clr_st_i) rflag_q <= 1'b0;
      if (fall_i && fen_i)          fflag_q <= 1'b1;
      else if (clr_f_i || clr_st_i) fflag_q <= 1'b0;
    end
  end

  assign rflag_o = rflag_q;
  assign fflag_o = fflag_q;
  assign stat_o  = lvl_i ? (ren_i & ~(smp_i ^ fen_i)) : (rflag_q | fflag_q);

  a_r9_rise_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && rise_i && ren_i) |=> rflag_o);
  a_r6_fall_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && fall_i && fen_i) |=> fflag_o);
  a_r10_level_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i |=> (!rflag_o && !fflag_o));
  a_r11_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && stat_o && !clr_r_i && !clr_f_i && !clr_st_i) |=> (stat_o || lvl_i));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NCH         = 8,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    pin_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH-1:0]    irq_o
);
  logic [NCH-1:0] smp, rise, fall;
  logic [NCH-1:0] mode, ren, fen, clr_r, clr_f, clr_st;
  logic [NCH-1:0] rflag, fflag, stat;

  pin_irq_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .pin_i,
    .smp_o(smp), .rise_o(rise), .fall_o(fall)
  );

  pin_irq_regs #(.NCH(NCH), .DW(DW)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .rflag_i(rflag), .fflag_i(fflag), .stat_i(stat),
    .mode_o(mode), .ren_o(ren), .fen_o(fen),
    .clr_r_o(clr_r), .clr_f_o(clr_f), .clr_st_o(clr_st)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pin_irq_chan i_chan (
      .clk_i, .rst_ni,
      .lvl_i(mode[c]), .ren_i(ren[c]), .fen_i(fen[c]),
      .smp_i(smp[c]), .rise_i(rise[c]), .fall_i(fall[c]),
      .clr_r_i(clr_r[c]), .clr_f_i(clr_f[c]), .clr_st_i(clr_st[c]),
      .rflag_o(rflag[c]), .fflag_o(fflag[c]), .stat_o(stat[c])
    );
  end

  assign irq_o = stat;
endmodule

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int checks = 0, errors = 0;
  logic [7:0] m_mode = 0, m_ren = 0, m_fen = 0, m_rf = 0, m_ff = 0, m_pin = 0;

  always #10 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] exp, input string tag);
    addr = a; #1;
    check(tag, rdata, {24'b0, exp});
  endtask

  function automatic logic [7:0] exp_stat();
    return (m_mode & m_ren & ~(m_pin ^ m_fen)) | (~m_mode & (m_rf | m_ff));
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] x);
    return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
  endfunction

  // write then one idle cycle; model updated per requirements
  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
    req = 1; we = 1; addr = a; wdata = {24'hFFFFFF, d};
    @(posedge clk); @(negedge clk);
    req = 0; we = 0; wdata = '0;
    @(negedge clk);
    case (a)
      6'h00: begin m_mode = d; m_rf &= ~d; m_ff &= ~d; end
      6'h04: m_ren = d;
      6'h08: m_ren |= d;
      6'h0C: m_ren &= ~d;
      6'h10: m_fen = d;
      6'h14: m_fen |= d;
      6'h18: m_fen &= ~d;
      6'h1C: m_rf &= ~d;
      6'h20: m_ff &= ~d;
      6'h24: begin m_rf &= ~d; m_ff &= ~d; end
      default: ;
    endcase
  endtask

  task automatic set_pins(input logic [7:0] v);
    m_rf |= ~m_mode & m_ren & v & ~m_pin;
    m_ff |= ~m_mode & m_fen & ~v & m_pin;
    m_pin = v; pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    rd_chk(6'h1C, m_rf, {tag, " R5 rising flags"});
    rd_chk(6'h20, m_ff, {tag, " R6 falling flags"});
    rd_chk(6'h24, exp_stat(), {tag, " R10 status"});
    check({tag, " R11 irq_o"}, {24'b0, irq}, {24'b0, exp_stat()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_chk(6'h00, 8'h00, "R1 mode");
    rd_chk(6'h04, 8'h00, "R1 ren");
    rd_chk(6'h10, 8'h00, "R1 fen");
    rd_chk(6'h1C, 8'h00, "R1 rflag");
    rd_chk(6'h20, 8'h00, "R1 fflag");
    rd_chk(6'h24, 8'h00, "R1 status");
    check("R1 irq_o", {24'b0, irq}, 32'h0);

    // R2 direct registers, alias reads, unmapped offset
    reg_wr(6'h00, 8'hA5); rd_chk(6'h00, 8'hA5, "R2 mode rd");
    reg_wr(6'h04, 8'h3C); rd_chk(6'h04, 8'h3C, "R2 ren rd");
    rd_chk(6'h08, 8'h3C, "R2 ren set alias rd");
    reg_wr(6'h10, 8'hC3); rd_chk(6'h18, 8'hC3, "R2 fen clr alias rd");
    rd_chk(6'h28, 8'h00, "R2 unmapped rd");
    rd_chk(6'h3C, 8'h00, "R2 unmapped high rd");
    reg_wr(6'h00, 8'h00); reg_wr(6'h04, 8'h00); reg_wr(6'h10, 8'h00);

    // R3 / R4 alias sweeps
    lf = 8'h5A;
    for (int i = 0; i < 24; i++) begin
      reg_wr(6'h08, lf);        rd_chk(6'h04, m_ren, "R3 ren set");
      reg_wr(6'h14, ~lf);       rd_chk(6'h10, m_fen, "R3 fen set");
      lf = nxt(lf);
      reg_wr(6'h0C, lf);        rd_chk(6'h04, m_ren, "R4 ren clr");
      reg_wr(6'h18, lf ^ 8'h33); rd_chk(6'h10, m_fen, "R4 fen clr");
      lf = nxt(lf);
    end
    reg_wr(6'h08, 8'h00); rd_chk(6'h04, m_ren, "R3 zero set no effect");
    reg_wr(6'h0C, 8'h00); rd_chk(6'h04, m_ren, "R4 zero clr no effect");

    // R5-R8 edge mode under several enable mixes
    reg_wr(6'h00, 8'h00);
    for (int cfg = 0; cfg < 4; cfg++) begin
      reg_wr(6'h04, (cfg == 0) ? 8'hFF : (cfg == 1) ? 8'h00 : (cfg == 2) ? 8'hF0 : 8'h5A);
      reg_wr(6'h10, (cfg == 0) ? 8'h00 : (cfg == 1) ? 8'hFF : (cfg == 2) ? 8'h3C : 8'hFF);
      reg_wr(6'h24, 8'hFF);
      check_all("R8 flush");
      for (int p = 0; p < 20; p++) begin
        set_pins(lf); lf = nxt(lf);
        check_all("R5 R6 edge");
        if (p % 5 == 4) begin
          reg_wr(6'h1C, lf);        check_all("R7 rflag clr");
          reg_wr(6'h20, ~lf);       check_all("R7 fflag clr");
          reg_wr(6'h24, lf ^ 8'h0F); check_all("R8 status clr");
        end
      end
    end

    // R10 level mode, both polarities
    reg_wr(6'h00, 8'hFF);
    check_all("R10 enter level");
    for (int cfg = 0; cfg < 4; cfg++) begin
      reg_wr(6'h04, (cfg == 3) ? 8'h96 : 8'hFF);
      reg_wr(6'h10, (cfg == 0) ? 8'hFF : (cfg == 1) ? 8'h00 : 8'hA5);
      for (int p = 0; p < 12; p++) begin
        set_pins(lf); lf = nxt(lf);
        check_all("R10 level");
        reg_wr(6'h24, 8'hFF);
        check_all("R10 status write ignored");
      end
    end

    // mixed modes
    reg_wr(6'h00, 8'h0F); reg_wr(6'h04, 8'hFF); reg_wr(6'h10, 8'h33);
    reg_wr(6'h24, 8'hFF);
    for (int p = 0; p < 16; p++) begin
      set_pins(lf); lf = nxt(lf);
      check_all("R11 mixed");
      if (p % 4 == 3) begin reg_wr(6'h24, 8'hFF); check_all("R11 mixed clr"); end
    end

    // R9 edge and clear in the same cycle on channel 3
    reg_wr(6'h00, 8'h00); reg_wr(6'h08, 8'h08);
    set_pins(m_pin & 8'hF7);
    reg_wr(6'h1C, 8'hFF); reg_wr(6'h20, 8'hFF);
    check_all("R9 setup");
    pin = m_pin | 8'h08;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    req = 1; we = 1; addr = 6'h1C; wdata = 32'h8;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0; wdata = '0;
    m_pin = pin; m_rf |= 8'h08;
    rd_chk(6'h1C, m_rf, "R9 edge beats clear");
    @(negedge clk);
    check_all("R9 after race");
    reg_wr(6'h24, 8'h08);
    check_all("R9 then status clr");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule